// File: doc/BRIEF.md
# Power-Mode State Controller

This block holds the power mode of a power-management chip: OFF, ACTIVE or SLEEP. It turns start-up, wake, sleep and shutdown events into per-resource controls: an enable and a low-power select for each regulator rail, an enable for the 32 kHz clock output, and a reset line to the host processor. The events come from a level hold input, a button press that is already debounced, a sleep request, a shutdown request and a few status flags from the host.

In SLEEP every rail drops to low-power unless software has set its bit in one of two keep-on masks. One mask covers the linear regulators. The other covers the switching rails and has one extra bit for the clock output. The processor reset stays low in OFF and for a programmable number of cycles after ACTIVE is entered from OFF. A small register write port loads the masks, the clock control bit and the reset delay.

Top module: `pmic_pwr_ctrl`

## Requirements
- R1: During and after reset the state is OFF (`state_o` = 2'b00; ACTIVE = 2'b01, SLEEP = 2'b10). In this state `cpu_rst_n`, every `ldo_en`/`ldo_lp`/`sw_en`/`sw_lp` bit and `clk32k_en` are low.
- R2: The hold input is sampled once per clock with no filtering. If it is high now and was low at the previous edge while in OFF with `pwr_dis` low, the state becomes ACTIVE at the next edge. If it is low now and was high at the previous edge, the state becomes OFF at the next edge from any state.
- R3: `hold_rise_irq` is high in exactly the cycles where `hold_in` is high and was low at the previous edge, in any state.
- R4: A `btn_press` pulse moves OFF to ACTIVE (when `pwr_dis` is low) and SLEEP to ACTIVE at the next edge.
- R5: While `pwr_dis` is high, neither a hold rising edge nor a button press leaves OFF.
- R6: `sleep_req` moves ACTIVE to SLEEP at the next edge. It has no effect in OFF.
- R7: After a button wake from SLEEP, `sleep_req` is ignored for as long as `irq_pend` stays high. The first cycle with `irq_pend` low ends this hold-off.
- R8: After a button start from OFF, a grace window of GRACE_CYC (default 16) cycles runs. If at its end `hold_in` is low and `host_en` is all zero, the state returns to OFF one edge later, so ACTIVE lasts GRACE_CYC+1 cycles. Otherwise ACTIVE continues and the window closes.
- R9: `cpu_rst_n` is low in OFF. It goes high N cycles after the edge that enters ACTIVE from OFF, where N is the reset-delay register (default 4; 0 means high at entry). It stays high through SLEEP and through a wake from SLEEP.
- R10: In OFF every rail has en=0 and lp=0. In ACTIVE every rail has en=1 and lp=0. In SLEEP every rail has en=1, and its lp is the inverse of its keep-on mask bit.
- R11: `clk32k_en` equals the clock control bit in ACTIVE, the clock keep bit in SLEEP, and 0 in OFF.
- R12: `shutdown_req` forces OFF at the next edge from any state. In the same cycle it drives every rail enable and `clk32k_en` low.
- R13: A write with `wr_en` high takes effect at the next edge. The address map is:
  - address 0: linear keep mask, bits [NUM_LDO-1:0].
  - address 1: switching keep mask, bits [NUM_SW-1:0], plus the clock keep bit at bit NUM_SW.
  - address 2: clock control, bit 0, reset value 1.
  - address 3: reset delay, bits [RST_W-1:0], reset value 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold_in | input | 1 | Level hold input, acted on at its edges |
| btn_press | input | 1 | One-cycle debounced button-press event |
| sleep_req | input | 1 | Request to enter SLEEP |
| host_en | input | NUM_EN | Host enabling-condition flags |
| irq_pend | input | 1 | Some interrupt is pending |
| pwr_dis | input | 1 | A power-on disable condition is present |
| shutdown_req | input | 1 | Forced shutdown from the button handler |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | DATA_W | Register write data |
| ldo_en | output | NUM_LDO | Linear regulator enables |
| ldo_lp | output | NUM_LDO | Linear regulator low-power selects |
| sw_en | output | NUM_SW | Switching rail enables |
| sw_lp | output | NUM_SW | Switching rail low-power selects |
| clk32k_en | output | 1 | 32 kHz clock output enable |
| cpu_rst_n | output | 1 | Active-low processor reset |
| hold_rise_irq | output | 1 | Hold rising-edge interrupt event |
| state_o | output | 2 | Current power state |

## Verification
A mode event presented before an edge shows up in `state_o` one edge later. The rail, clock and reset outputs are combinational from that state, so they settle in the same cycle. Shutdown gating and `hold_rise_irq` respond to the inputs within the cycle, before any edge. The reset release is due exactly N edges after entry, and the grace-window shutdown comes GRACE_CYC+1 edges after the button start. The bench drives inputs on falling edges and samples one falling edge later for registered results. It samples a few nanoseconds after driving for the same-cycle results, and it counts edges explicitly for the two timed windows.

// File: rtl/pmic_pwr_pkg.sv
`timescale 1ns/1ps
package pmic_pwr_pkg;

  typedef enum logic [1:0] {
    PS_OFF    = 2'b00,
    PS_ACTIVE = 2'b01,
    PS_SLEEP  = 2'b10
  } pwr_state_e;

  localparam logic [1:0] REG_LDO_KEEP = 2'd0;
  localparam logic [1:0] REG_SW_KEEP  = 2'd1;
  localparam logic [1:0] REG_CLK_CTL  = 2'd2;
  localparam logic [1:0] REG_RST_DLY  = 2'd3;

  // {enable, low_power} for one rail
  function automatic logic [1:0] rail_ctrl(pwr_state_e st, logic keep, logic kill);
    logic [1:0] r;
    r = 2'b00;
    if (!kill) begin
      case (st)
        PS_ACTIVE: r = 2'b10;
        PS_SLEEP:  r = {1'b1, ~keep};
        default:   r = 2'b00;
      endcase
    end
    return r;
  endfunction

  function automatic logic clk_ctrl(pwr_state_e st, logic act_on, logic sleep_keep,
                                    logic kill);
    logic c;
    c = 1'b0;
    if (!kill) begin
      case (st)
        PS_ACTIVE: c = act_on;
        PS_SLEEP:  c = sleep_keep;
        default:   c = 1'b0;
      endcase
    end
    return c;
  endfunction

endpackage

// File: rtl/pmic_cfg_regs.sv
`timescale 1ns/1ps
module pmic_cfg_regs
  import pmic_pwr_pkg::*;
#(
  parameter int NUM_LDO     = 8,
  parameter int NUM_SW      = 4,
  parameter int DATA_W      = 8,
  parameter int RST_W       = 4,
  parameter int RST_DLY_DEF = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_LDO-1:0] ldo_keep,
  output logic [NUM_SW-1:0]  sw_keep,
  output logic               clk_keep,
  output logic               clk_act_on,
  output logic [RST_W-1:0]   rst_dly
);

  logic unused_wdata_bits;
  assign unused_wdata_bits = ^wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldo_keep   <= '0;
      sw_keep    <= '0;
      clk_keep   <= 1'b0;
      clk_act_on <= 1'b1;
      rst_dly    <= RST_W'(RST_DLY_DEF);
    end else if (wr_en) begin
      case (wr_addr)
        REG_LDO_KEEP: ldo_keep <= wr_data[NUM_LDO-1:0];
        REG_SW_KEEP: begin
          sw_keep  <= wr_data[NUM_SW-1:0];
          clk_keep <= wr_data[NUM_SW];
        end
        REG_CLK_CTL: clk_act_on <= wr_data[0];
        default:     rst_dly    <= wr_data[RST_W-1:0];
      endcase
    end
  end

  // R13
  dly_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_RST_DLY) |=> (rst_dly == $past(wr_data[RST_W-1:0])));

  // R13
  ldo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == REG_LDO_KEEP) |=> (ldo_keep == $past(wr_data[NUM_LDO-1:0])));

endmodule

// File: rtl/pmic_mode_fsm.sv
`timescale 1ns/1ps
module pmic_mode_fsm
  import pmic_pwr_pkg::*;
#(
  parameter int NUM_EN    = 2,
  parameter int GRACE_CYC = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_in,
  input  logic              btn_press,
  input  logic              sleep_req,
  input  logic [NUM_EN-1:0] host_en,
  input  logic              irq_pend,
  input  logic              pwr_dis,
  input  logic              shutdown_req,
  output pwr_state_e        state,
  output logic              boot_entry,
  output logic              hold_rise
);

  localparam int GRACE_W = $clog2(GRACE_CYC + 1);

  pwr_state_e         st_q, st_d;
  logic               hold_q;
  logic               hold_fall;
  logic               wake_lock_q;
  logic               grace_arm_q;
  logic [GRACE_W-1:0] grace_cnt_q;
  logic               btn_boot;
  logic               btn_wake;
  logic               sleep_block;
  logic               grace_expire;

  assign hold_rise    = hold_in & ~hold_q;
  assign hold_fall    = ~hold_in & hold_q;
  assign sleep_block  = wake_lock_q & irq_pend;
  assign grace_expire = (st_q == PS_ACTIVE) && grace_arm_q && (grace_cnt_q == '0) &&
                        !hold_in && (host_en == '0);
  assign state        = st_q;
  assign boot_entry   = (st_q == PS_OFF) && (st_d == PS_ACTIVE);

  always_comb begin
    st_d     = st_q;
    btn_boot = 1'b0;
    btn_wake = 1'b0;
    if (shutdown_req) begin
      st_d = PS_OFF;
    end else begin
      case (st_q)
        PS_OFF: begin
          if (!pwr_dis && hold_rise) begin
            st_d = PS_ACTIVE;
          end else if (!pwr_dis && btn_press) begin
            st_d     = PS_ACTIVE;
            btn_boot = 1'b1;
          end
        end
        PS_ACTIVE: begin
          if (hold_fall || grace_expire) st_d = PS_OFF;
          else if (sleep_req && !sleep_block) st_d = PS_SLEEP;
        end
        PS_SLEEP: begin
          if (hold_fall) begin
            st_d = PS_OFF;
          end else if (btn_press) begin
            st_d     = PS_ACTIVE;
            btn_wake = 1'b1;
          end
        end
        default: st_d = PS_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= PS_OFF;
      hold_q      <= 1'b0;
      wake_lock_q <= 1'b0;
      grace_arm_q <= 1'b0;
      grace_cnt_q <= '0;
    end else begin
      st_q   <= st_d;
      hold_q <= hold_in;
      if (btn_wake)                           wake_lock_q <= 1'b1;
      else if (!irq_pend || st_d != PS_ACTIVE) wake_lock_q <= 1'b0;
      if (st_d != PS_ACTIVE) begin
        grace_arm_q <= 1'b0;
      end else if (btn_boot) begin
        grace_arm_q <= 1'b1;
        grace_cnt_q <= GRACE_W'(GRACE_CYC);
      end else if (grace_arm_q) begin
        if (grace_cnt_q == '0) grace_arm_q <= 1'b0;
        else                   grace_cnt_q <= grace_cnt_q - 1'b1;
      end
    end
  end

  // R12
  shutdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |=> (st_q == PS_OFF));

  // R2
  hold_fall_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_fall |=> (st_q == PS_OFF));

  // R6
  no_sleep_from_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_OFF) |=> (st_q != PS_SLEEP));

  // R7
  wake_lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_ACTIVE && wake_lock_q && irq_pend) |=> (st_q != PS_SLEEP));

  // R5
  dis_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_OFF && pwr_dis) |=> (st_q == PS_OFF));

endmodule

// File: rtl/pmic_rst_timer.sv
`timescale 1ns/1ps
module pmic_rst_timer
  import pmic_pwr_pkg::*;
#(
  parameter int RST_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pwr_state_e       state,
  input  logic             boot_entry,
  input  logic [RST_W-1:0] rst_dly,
  output logic             cpu_rst_n
);

  logic [RST_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (boot_entry) begin
      cnt_q <= rst_dly;
    end else if (state != PS_OFF && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cpu_rst_n = (state != PS_OFF) && (cnt_q == '0);

  // R9
  off_holds_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_OFF) |-> !cpu_rst_n);

  // R9
  entry_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boot_entry && rst_dly != '0) |=> !cpu_rst_n);

endmodule

// File: rtl/pmic_out_map.sv
`timescale 1ns/1ps
module pmic_out_map
  import pmic_pwr_pkg::*;
#(
  parameter int NUM_LDO = 8,
  parameter int NUM_SW  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pwr_state_e         state,
  input  logic               kill,
  input  logic [NUM_LDO-1:0] ldo_keep,
  input  logic [NUM_SW-1:0]  sw_keep,
  input  logic               clk_keep,
  input  logic               clk_act_on,
  output logic [NUM_LDO-1:0] ldo_en,
  output logic [NUM_LDO-1:0] ldo_lp,
  output logic [NUM_SW-1:0]  sw_en,
  output logic [NUM_SW-1:0]  sw_lp,
  output logic               clk32k_en
);

  for (genvar i = 0; i < NUM_LDO; i++) begin : g_ldo
    assign {ldo_en[i], ldo_lp[i]} = rail_ctrl(state, ldo_keep[i], kill);
  end

  for (genvar j = 0; j < NUM_SW; j++) begin : g_sw
    assign {sw_en[j], sw_lp[j]} = rail_ctrl(state, sw_keep[j], kill);
  end

  assign clk32k_en = clk_ctrl(state, clk_act_on, clk_keep, kill);

  // R10
  off_rails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_OFF) |-> (ldo_en == '0 && sw_en == '0 && ldo_lp == '0 && sw_lp == '0));

  // R10
  active_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_ACTIVE && !kill) |-> (ldo_lp == '0 && sw_lp == '0 && ldo_en == '1));

endmodule

// File: rtl/pmic_pwr_ctrl.sv
`timescale 1ns/1ps
module pmic_pwr_ctrl
  import pmic_pwr_pkg::*;
#(
  parameter int NUM_LDO     = 8,
  parameter int NUM_SW      = 4,
  parameter int NUM_EN      = 2,
  parameter int DATA_W      = 8,
  parameter int RST_W       = 4,
  parameter int RST_DLY_DEF = 4,
  parameter int GRACE_CYC   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               hold_in,
  input  logic               btn_press,
  input  logic               sleep_req,
  input  logic [NUM_EN-1:0]  host_en,
  input  logic               irq_pend,
  input  logic               pwr_dis,
  input  logic               shutdown_req,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic [NUM_LDO-1:0] ldo_en,
  output logic [NUM_LDO-1:0] ldo_lp,
  output logic [NUM_SW-1:0]  sw_en,
  output logic [NUM_SW-1:0]  sw_lp,
  output logic               clk32k_en,
  output logic               cpu_rst_n,
  output logic               hold_rise_irq,
  output logic [1:0]         state_o
);

  pwr_state_e         state;
  logic               boot_entry;
  logic [NUM_LDO-1:0] ldo_keep;
  logic [NUM_SW-1:0]  sw_keep;
  logic               clk_keep;
  logic               clk_act_on;
  logic [RST_W-1:0]   rst_dly;

  pmic_cfg_regs #(
    .NUM_LDO(NUM_LDO), .NUM_SW(NUM_SW), .DATA_W(DATA_W),
    .RST_W(RST_W), .RST_DLY_DEF(RST_DLY_DEF)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ldo_keep(ldo_keep), .sw_keep(sw_keep), .clk_keep(clk_keep),
    .clk_act_on(clk_act_on), .rst_dly(rst_dly)
  );

  pmic_mode_fsm #(.NUM_EN(NUM_EN), .GRACE_CYC(GRACE_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hold_in(hold_in), .btn_press(btn_press),
    .sleep_req(sleep_req), .host_en(host_en), .irq_pend(irq_pend),
    .pwr_dis(pwr_dis), .shutdown_req(shutdown_req), .state(state),
    .boot_entry(boot_entry), .hold_rise(hold_rise_irq)
  );

  pmic_rst_timer #(.RST_W(RST_W)) u_rst (
    .clk(clk), .rst_n(rst_n), .state(state), .boot_entry(boot_entry),
    .rst_dly(rst_dly), .cpu_rst_n(cpu_rst_n)
  );

  pmic_out_map #(.NUM_LDO(NUM_LDO), .NUM_SW(NUM_SW)) u_out (
    .clk(clk), .rst_n(rst_n), .state(state), .kill(shutdown_req),
    .ldo_keep(ldo_keep), .sw_keep(sw_keep), .clk_keep(clk_keep),
    .clk_act_on(clk_act_on), .ldo_en(ldo_en), .ldo_lp(ldo_lp),
    .sw_en(sw_en), .sw_lp(sw_lp), .clk32k_en(clk32k_en)
  );

  assign state_o = state;

  // R12
  shutdown_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_req |-> (ldo_en == '0 && sw_en == '0 && !clk32k_en));

  // R11
  off_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00) |-> !clk32k_en);

endmodule

// File: tb/tb_pmic_pwr_ctrl.sv
`timescale 1ns/1ps
module tb_pmic_pwr_ctrl;

  localparam int NUM_LDO = 8;
  localparam int NUM_SW  = 4;
  localparam int NUM_EN  = 2;
  localparam int DATA_W  = 8;
  localparam int GRACE   = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_in = 1'b0, btn_press = 1'b0, sleep_req = 1'b0, irq_pend = 1'b0;
  logic pwr_dis = 1'b0, shutdown_req = 1'b0, wr_en = 1'b0;
  logic [NUM_EN-1:0]  host_en = '0;
  logic [1:0]         wr_addr = '0;
  logic [DATA_W-1:0]  wr_data = '0;
  logic [NUM_LDO-1:0] ldo_en, ldo_lp;
  logic [NUM_SW-1:0]  sw_en, sw_lp;
  logic               clk32k_en, cpu_rst_n, hold_rise_irq;
  logic [1:0]         state_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pmic_pwr_ctrl dut (
    .clk(clk), .rst_n(rst_n), .hold_in(hold_in), .btn_press(btn_press),
    .sleep_req(sleep_req), .host_en(host_en), .irq_pend(irq_pend),
    .pwr_dis(pwr_dis), .shutdown_req(shutdown_req), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ldo_en(ldo_en), .ldo_lp(ldo_lp),
    .sw_en(sw_en), .sw_lp(sw_lp), .clk32k_en(clk32k_en), .cpu_rst_n(cpu_rst_n),
    .hold_rise_irq(hold_rise_irq), .state_o(state_o)
  );

  // {hold, btn, sleep, host_en[1:0], irq, shutdown, exp_state[1:0], exp_rst_n}
  localparam int TBL_N = 21;
  localparam logic [9:0] TBL [TBL_N] = '{
    10'b0_0_0_00_0_0_00_0,  // idle OFF
    10'b0_0_1_00_0_0_00_0,  // R6 sleep ignored in OFF
    10'b1_0_0_00_0_0_01_0,  // R2 hold rise
    10'b1_0_0_00_0_0_01_0,
    10'b1_0_0_00_0_0_01_0,
    10'b1_0_0_00_0_0_01_0,
    10'b1_0_0_00_0_0_01_1,  // R9 release after 4
    10'b1_0_1_00_0_0_10_1,  // R6 sleep
    10'b1_0_0_00_0_0_10_1,
    10'b0_0_0_00_0_0_00_0,  // R2 hold fall from SLEEP
    10'b0_1_0_01_0_0_01_0,  // R4 button start
    10'b0_0_0_01_0_0_01_0,
    10'b0_0_0_01_0_0_01_0,
    10'b0_0_0_01_0_0_01_0,
    10'b0_0_0_01_0_0_01_1,
    10'b0_0_1_01_0_0_10_1,
    10'b0_1_0_01_1_0_01_1,  // R4 wake, R9 no reload
    10'b0_0_1_01_1_0_01_1,  // R7 sleep held off
    10'b0_0_1_01_0_0_10_1,  // R7 released
    10'b0_0_0_01_0_1_00_0,  // R12 shutdown from SLEEP
    10'b1_0_0_01_0_0_01_0   // R2 hold rise again
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [DATA_W-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 state in reset", 32'(state_o), 32'h0);
    chk("R1 cpu_rst_n in reset", 32'(cpu_rst_n), 32'h0);
    chk("R1 rails in reset", {ldo_en, ldo_lp, sw_en, sw_lp}, 32'h0);
    chk("R1 clock in reset", 32'(clk32k_en), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 state after reset", 32'(state_o), 32'h0);

    for (int i = 0; i < TBL_N; i++) begin
      {hold_in, btn_press, sleep_req, host_en, irq_pend, shutdown_req} = TBL[i][9:3];
      @(negedge clk);
      chk($sformatf("row %0d state R2 R4 R6 R7 R12", i), 32'(state_o), 32'(TBL[i][2:1]));
      chk($sformatf("row %0d R9 reset", i), 32'(cpu_rst_n), 32'(TBL[i][0]));
    end
    btn_press = 1'b0; sleep_req = 1'b0; shutdown_req = 1'b0; host_en = '0;
    repeat (4) @(negedge clk);
    chk("R9 released in ACTIVE", 32'(cpu_rst_n), 32'h1);

    // R13 masks, R10 rails, R11 clock
    wr_reg(2'd0, 8'hA5);
    wr_reg(2'd1, 8'h13);
    chk("R10 ACTIVE ldo_en", 32'(ldo_en), 32'hFF);
    chk("R10 ACTIVE lp", {ldo_lp, sw_lp}, 32'h0);
    chk("R11 ACTIVE clock default", 32'(clk32k_en), 32'h1);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R6 entered SLEEP", 32'(state_o), 32'h2);
    chk("R10 SLEEP ldo_en", 32'(ldo_en), 32'hFF);
    chk("R10 R13 SLEEP ldo_lp", 32'(ldo_lp), 32'h5A);
    chk("R10 SLEEP sw_en", 32'(sw_en), 32'hF);
    chk("R10 R13 SLEEP sw_lp", 32'(sw_lp), 32'hC);
    chk("R11 SLEEP clock kept", 32'(clk32k_en), 32'h1);
    wr_reg(2'd1, 8'h03);
    chk("R11 R13 SLEEP clock dropped", 32'(clk32k_en), 32'h0);
    btn_press = 1'b1;
    @(negedge clk);
    btn_press = 1'b0;
    chk("R4 wake", 32'(state_o), 32'h1);
    chk("R11 clock back in ACTIVE", 32'(clk32k_en), 32'h1);
    wr_reg(2'd2, 8'h00);
    chk("R11 R13 clock control off", 32'(clk32k_en), 32'h0);
    wr_reg(2'd2, 8'h01);

    // R12 same-cycle kill
    shutdown_req = 1'b1;
    #5;
    chk("R12 state not yet moved", 32'(state_o), 32'h1);
    chk("R12 rails killed same cycle", {ldo_en, sw_en}, 32'h0);
    chk("R12 clock killed same cycle", 32'(clk32k_en), 32'h0);
    @(negedge clk);
    shutdown_req = 1'b0;
    chk("R12 OFF after edge", 32'(state_o), 32'h0);
    hold_in = 1'b0;
    @(negedge clk);

    // R5 disable, R3 interrupt
    pwr_dis = 1'b1;
    hold_in = 1'b1;
    #5;
    chk("R3 rise event", 32'(hold_rise_irq), 32'h1);
    @(negedge clk);
    chk("R5 hold blocked", 32'(state_o), 32'h0);
    chk("R3 no event on steady high", 32'(hold_rise_irq), 32'h0);
    hold_in = 1'b0;
    btn_press = 1'b1;
    @(negedge clk);
    btn_press = 1'b0;
    chk("R5 button blocked", 32'(state_o), 32'h0);
    pwr_dis = 1'b0;

    // R9 programmable delay
    wr_reg(2'd3, 8'h00);
    hold_in = 1'b1;
    @(negedge clk);
    chk("R9 delay 0 state", 32'(state_o), 32'h1);
    chk("R9 delay 0 released at entry", 32'(cpu_rst_n), 32'h1);
    hold_in = 1'b0;
    @(negedge clk);
    chk("R2 fall to OFF", 32'(state_o), 32'h0);
    wr_reg(2'd3, 8'h02);
    hold_in = 1'b1;
    @(negedge clk);
    chk("R9 delay 2 cycle 0", 32'(cpu_rst_n), 32'h0);
    @(negedge clk);
    chk("R9 delay 2 cycle 1", 32'(cpu_rst_n), 32'h0);
    @(negedge clk);
    chk("R9 delay 2 cycle 2", 32'(cpu_rst_n), 32'h1);
    hold_in = 1'b0;
    @(negedge clk);

    // R8 grace window expiry
    btn_press = 1'b1;
    @(negedge clk);
    btn_press = 1'b0;
    chk("R8 button start", 32'(state_o), 32'h1);
    begin
      int left = 0;
      repeat (GRACE) begin
        @(negedge clk);
        if (state_o != 2'b01) left++;
      end
      chk("R8 ACTIVE through window", 32'(left), 32'h0);
    end
    @(negedge clk);
    chk("R8 OFF after window", 32'(state_o), 32'h0);

    // R8 window passes with host flag set
    host_en = 2'b10;
    btn_press = 1'b1;
    @(negedge clk);
    btn_press = 1'b0;
    repeat (GRACE + 4) @(negedge clk);
    chk("R8 kept by host flag", 32'(state_o), 32'h1);
    host_en = '0;
    repeat (3) @(negedge clk);
    chk("R8 window closed", 32'(state_o), 32'h1);

    finish_run();
  end

endmodule